// File: doc/BRIEF.md
# Paged Address Translator with Debug Overlay

This block turns a 16-bit local CPU address into an 18-bit global address for a microcontroller memory map of 256KB. The local space is split into four 16KB quarters. The lowest two quarters and the highest quarter always map to fixed global pages. The third quarter is a paging window whose page comes from a 4-bit page index register, which software writes through a small write port and can read back.

While active debug mode is set, the block also overlays a small region of debug resources. The top 256 bytes of the local map always form this region. When the page register holds the top page, the last 256 bytes of the paging window alias to the same region. Debug resources are selected only during qualified debug access cycles. Inside the overlay, the normal resources are hidden. Outside active debug mode the overlay does not exist. Every access then reaches the normal resources.

Top module: `pgx_top`

## Requirements
- R1: After reset the page register holds 0xE and reads back as 0x0E on `pg_rd_data`. With that value, local 0x0000..0xFFFF maps linearly onto global 0x30000..0x3FFFF.
- R2: Local 0x8000..0xBFFF (top bits 2'b10) maps to global {page, local[13:0]}.
- R3: Local 0xC000..0xFFFF maps to global page 0xF whatever the page register holds.
- R4: Local 0x0000..0x3FFF maps to page 0xC and local 0x4000..0x7FFF maps to page 0xD, whatever the page register holds.
- R5: A write on the page port changes the page from the cycle after the write edge. An access in the same cycle as the write still uses the old page. Only written bits [3:0] are kept, and bits [7:4] of the readback are zero.
- R6: With `dbg_active` high, an access to local 0xFF00..0xFFFF selects the debug resources (`dbg_sel`) when `dbg_cycle` is high, and never the normal resources. The global address is 0x3FF00..0x3FFFF.
- R7: With `dbg_active` high and the page register at 0xF, local 0xBF00..0xBFFF is treated as part of the debug overlay in the same way as R6. With any other page, that range reaches the normal resources.
- R8: An access inside the active overlay without `dbg_cycle` selects neither resource.
- R9: With `dbg_active` low, every access, including one to 0xFFxx with `dbg_cycle` high, selects the normal resources and never the debug resources.
- R10: A select is asserted only while `rd_en` or `wr_en` is high. `dbg_sel` and `norm_sel` are never high together, for any address, page or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Local CPU address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| pg_wr_en | input | 1 | Page register write enable |
| pg_wr_data | input | 8 | Page register write data |
| pg_rd_data | output | 8 | Page register readback, upper bits zero |
| dbg_active | input | 1 | Active debug mode flag |
| dbg_cycle | input | 1 | Access is a dedicated debug read/write cycle |
| glb_addr | output | 18 | Global address |
| dbg_sel | output | 1 | Debug resource select |
| norm_sel | output | 1 | Normal resource select |

## Verification
A page register write and an access through the window alias can fall in the same cycle. The bench provokes this by writing page 0xF on the same clock as a debug-qualified read of 0xBF10 in active debug mode. Before the edge, the access must still reach the normal resources under the old page. From the next cycle on, it must select the debug resources. A sweep over all pages, both debug flags, the qualifier and a grid of addresses compares every output with an independent model and checks that the two selects are exclusive.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int LADDR_W    = 16;
    localparam int PAGE_W     = 4;
    localparam int REGION_W   = 2;
    localparam int WIN_W      = LADDR_W - REGION_W;
    localparam int GADDR_W    = PAGE_W + WIN_W;
    localparam int PG_BUS_W   = 8;
    localparam int OVL_SPAN_W = 8;
    localparam int OVL_HI_W   = LADDR_W - OVL_SPAN_W;

    typedef logic [PAGE_W-1:0]  page_t;
    typedef logic [LADDR_W-1:0] laddr_t;

    typedef enum logic [REGION_W-1:0] {
        REG_LOW = 2'd0,
        REG_MID = 2'd1,
        REG_WIN = 2'd2,
        REG_TOP = 2'd3
    } region_e;

    localparam page_t TOP_PAGE   = '1;
    localparam page_t RESET_PAGE = TOP_PAGE - page_t'(1);
    localparam page_t MID_PAGE   = TOP_PAGE - page_t'(2);
    localparam page_t LOW_PAGE   = TOP_PAGE - page_t'(3);

    typedef struct packed {
        page_t              page;
        logic [WIN_W-1:0]   offset;
    } gaddr_t;

    typedef struct packed {
        logic dbg;
        logic norm;
    } sel_t;

    function automatic region_e region_of(laddr_t a);
        return region_e'(a[LADDR_W-1 -: REGION_W]);
    endfunction

    function automatic logic [OVL_HI_W-1:0] hi_of(laddr_t a);
        return a[LADDR_W-1 -: OVL_HI_W];
    endfunction
endpackage

// File: rtl/pgx_page_reg.sv
module pgx_page_reg
    import pgx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [PG_BUS_W-1:0] wr_data,
    output page_t               page_o,
    output logic [PG_BUS_W-1:0] rd_data
);
    page_t page_q;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= RESET_PAGE;
        else if (wr_en)
            page_q <= wr_data[PAGE_W-1:0];
    end

    assign page_o  = page_q;
    assign rd_data = {{(PG_BUS_W-PAGE_W){1'b0}}, page_q};

    // R5: a write is visible exactly one cycle later
    p_page_load_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[PAGE_W-1:0] == $past(wr_data[PAGE_W-1:0])))
        else $error("p_page_load_r5");

    // R5: without a write the page holds
    p_page_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(page_o))
        else $error("p_page_hold_r5");
endmodule

// File: rtl/pgx_addr_map.sv
module pgx_addr_map
    import pgx_pkg::*;
(
    input  laddr_t laddr,
    input  page_t  page,
    output gaddr_t gaddr
);
    region_e reg_q;
    page_t   sel_page;

    assign reg_q = region_of(laddr);

    always_comb begin
        unique case (reg_q)
            REG_LOW: sel_page = LOW_PAGE;
            REG_MID: sel_page = MID_PAGE;
            REG_WIN: sel_page = page;
            default: sel_page = TOP_PAGE;
        endcase
    end

    assign gaddr.page   = sel_page;
    assign gaddr.offset = laddr[WIN_W-1:0];
endmodule

// File: rtl/pgx_overlay_dec.sv
module pgx_overlay_dec
    import pgx_pkg::*;
(
    input  laddr_t laddr,
    input  page_t  page,
    input  logic   dbg_active,
    input  logic   dbg_cycle,
    input  logic   access,
    output logic   in_overlay,
    output sel_t   sel
);
    localparam logic [OVL_HI_W-1:0] TOP_HI   = '1;
    localparam logic [OVL_HI_W-1:0] ALIAS_HI =
        {REG_WIN, {(OVL_HI_W-REGION_W){1'b1}}};

    logic top_hit;
    logic alias_hit;

    assign top_hit    = (hi_of(laddr) == TOP_HI);
    assign alias_hit  = (hi_of(laddr) == ALIAS_HI) && (page == TOP_PAGE);
    assign in_overlay = dbg_active && (top_hit || alias_hit);

    assign sel.dbg  = access && in_overlay && dbg_cycle;
    assign sel.norm = access && !in_overlay;
endmodule

// File: rtl/pgx_top.sv
module pgx_top
    import pgx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LADDR_W-1:0]   cpu_addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic                 pg_wr_en,
    input  logic [PG_BUS_W-1:0]  pg_wr_data,
    output logic [PG_BUS_W-1:0]  pg_rd_data,
    input  logic                 dbg_active,
    input  logic                 dbg_cycle,
    output logic [GADDR_W-1:0]   glb_addr,
    output logic                 dbg_sel,
    output logic                 norm_sel
);
    page_t  page;
    gaddr_t gaddr;
    sel_t   sel;
    logic   in_overlay;
    logic   access;

    assign access = rd_en || wr_en;

    pgx_page_reg u_page (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pg_wr_en),
        .wr_data (pg_wr_data),
        .page_o  (page),
        .rd_data (pg_rd_data)
    );

    pgx_addr_map u_map (
        .laddr (cpu_addr),
        .page  (page),
        .gaddr (gaddr)
    );

    pgx_overlay_dec u_ovl (
        .laddr      (cpu_addr),
        .page       (page),
        .dbg_active (dbg_active),
        .dbg_cycle  (dbg_cycle),
        .access     (access),
        .in_overlay (in_overlay),
        .sel        (sel)
    );

    assign glb_addr = gaddr;
    assign dbg_sel  = sel.dbg;
    assign norm_sel = sel.norm;

    // R10: selects are exclusive
    p_sel_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(dbg_sel && norm_sel))
        else $error("p_sel_excl_r10");

    // R10: no select without a strobe
    p_sel_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel || norm_sel) |-> (rd_en || wr_en))
        else $error("p_sel_strobe_r10");

    // R8: debug select needs both the mode and the qualifier
    p_dbg_qual_r8: assert property (@(posedge clk) disable iff (rst)
        dbg_sel |-> (dbg_active && dbg_cycle))
        else $error("p_dbg_qual_r8");

    // R9: outside debug mode every access is normal
    p_dbg_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!dbg_active && (rd_en || wr_en)) |-> norm_sel)
        else $error("p_dbg_off_r9");

    // R3: top quarter is always the fixed page
    p_top_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[LADDR_W-1 -: REGION_W] == 2'b11) |->
            (glb_addr[GADDR_W-1 -: PAGE_W] == TOP_PAGE))
        else $error("p_top_fixed_r3");

    // R2: window page follows the readable page register
    p_window_page_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[LADDR_W-1 -: REGION_W] == 2'b10) |->
            (glb_addr[GADDR_W-1 -: PAGE_W] == pg_rd_data[PAGE_W-1:0]))
        else $error("p_window_page_r2");
endmodule

// File: tb/pgx_top_bench.sv
module pgx_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        pg_wr_en = 1'b0;
    logic [7:0]  pg_wr_data = '0;
    logic [7:0]  pg_rd_data;
    logic        dbg_active = 1'b0;
    logic        dbg_cycle = 1'b0;
    logic [17:0] glb_addr;
    logic        dbg_sel;
    logic        norm_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgx_top u_pgx_top (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .pg_wr_en   (pg_wr_en),
        .pg_wr_data (pg_wr_data),
        .pg_rd_data (pg_rd_data),
        .dbg_active (dbg_active),
        .dbg_cycle  (dbg_cycle),
        .glb_addr   (glb_addr),
        .dbg_sel    (dbg_sel),
        .norm_sel   (norm_sel)
    );

    // independent model built from the requirements
    function automatic logic [17:0] m_glb(logic [15:0] a, logic [3:0] pg);
        logic [3:0] p;
        case (a[15:14])
            2'b00:   p = 4'hC;
            2'b01:   p = 4'hD;
            2'b10:   p = pg;
            default: p = 4'hF;
        endcase
        return {p, a[13:0]};
    endfunction

    function automatic logic m_ovl(logic [15:0] a, logic [3:0] pg, logic act);
        return act && ((a[15:8] == 8'hFF) || (a[15:8] == 8'hBF && pg == 4'hF));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_page(logic [7:0] v);
        @(negedge clk);
        pg_wr_en = 1'b1;
        pg_wr_data = v;
        @(negedge clk);
        pg_wr_en = 1'b0;
    endtask

    task automatic drive(logic [15:0] a, logic rd, logic wr, logic act, logic cyc);
        cpu_addr = a; rd_en = rd; wr_en = wr; dbg_active = act; dbg_cycle = cyc;
        #1;
    endtask

    task automatic t_reset;
        chk("R1", "reset readback", 32'(pg_rd_data), 32'h0E);
        drive(16'h0000, 1, 0, 0, 0);
        chk("R1", "glb 0x0000", 32'(glb_addr), 32'h30000);
        drive(16'h8123, 1, 0, 0, 0);
        chk("R1", "glb 0x8123", 32'(glb_addr), 32'h38123);
        drive(16'hFFFF, 1, 0, 0, 0);
        chk("R1", "glb 0xFFFF", 32'(glb_addr), 32'h3FFFF);
    endtask

    task automatic t_fixed;
        wr_page(8'h03);
        drive(16'h1234, 1, 0, 0, 0);
        chk("R4", "low quarter", 32'(glb_addr), 32'h31234);
        drive(16'h5678, 0, 1, 0, 0);
        chk("R4", "mid quarter", 32'(glb_addr), 32'h35678);
        drive(16'hC010, 1, 0, 0, 0);
        chk("R3", "top quarter page 3", 32'(glb_addr), 32'h3C010);
    endtask

    task automatic t_window;
        wr_page(8'h00);
        drive(16'h8000, 1, 0, 0, 0);
        chk("R2", "window page 0", 32'(glb_addr), 32'h00000);
        wr_page(8'h07);
        drive(16'hBFFF, 1, 0, 0, 0);
        chk("R2", "window page 7", 32'(glb_addr), 32'h1FFFF);
    endtask

    task automatic t_page_write;
        wr_page(8'hA5);
        chk("R5", "upper bits dropped", 32'(pg_rd_data), 32'h05);
        wr_page(8'h0E);
        // write page F while reading the alias in debug mode, same cycle
        @(negedge clk);
        pg_wr_en = 1'b1; pg_wr_data = 8'h0F;
        drive(16'hBF10, 1, 0, 1, 1);
        chk("R5", "old page dbg_sel", 32'(dbg_sel), 32'd0);
        chk("R5", "old page norm_sel", 32'(norm_sel), 32'd1);
        chk("R5", "old page glb", 32'(glb_addr), 32'h3BF10);
        @(negedge clk);
        pg_wr_en = 1'b0;
        #1;
        chk("R5", "new page dbg_sel", 32'(dbg_sel), 32'd1);
        chk("R5", "new page readback", 32'(pg_rd_data), 32'h0F);
    endtask

    task automatic t_dbg_top;
        wr_page(8'h02);
        drive(16'hFF00, 1, 0, 1, 1);
        chk("R6", "dbg_sel FF00", 32'(dbg_sel), 32'd1);
        chk("R6", "norm_sel FF00", 32'(norm_sel), 32'd0);
        chk("R6", "glb FF00", 32'(glb_addr), 32'h3FF00);
        drive(16'hFEFF, 1, 0, 1, 1);
        chk("R6", "FEFF stays normal", 32'(norm_sel), 32'd1);
    endtask

    task automatic t_dbg_alias;
        wr_page(8'h0F);
        drive(16'hBF80, 0, 1, 1, 1);
        chk("R7", "alias dbg_sel", 32'(dbg_sel), 32'd1);
        chk("R7", "alias glb", 32'(glb_addr), 32'h3FF80);
        drive(16'hBEFF, 0, 1, 1, 1);
        chk("R7", "below alias normal", 32'(norm_sel), 32'd1);
        wr_page(8'h0E);
        drive(16'hBF80, 0, 1, 1, 1);
        chk("R7", "page E no alias", 32'(norm_sel), 32'd1);
    endtask

    task automatic t_no_cycle;
        drive(16'hFF40, 1, 0, 1, 0);
        chk("R8", "no qualifier dbg_sel", 32'(dbg_sel), 32'd0);
        chk("R8", "no qualifier norm_sel", 32'(norm_sel), 32'd0);
    endtask

    task automatic t_dbg_off;
        drive(16'hFF40, 1, 0, 0, 1);
        chk("R9", "inactive dbg_sel", 32'(dbg_sel), 32'd0);
        chk("R9", "inactive norm_sel", 32'(norm_sel), 32'd1);
    endtask

    task automatic t_no_strobe;
        drive(16'hFF40, 0, 0, 1, 1);
        chk("R10", "no strobe dbg_sel", 32'(dbg_sel), 32'd0);
        drive(16'h1000, 0, 0, 0, 0);
        chk("R10", "no strobe norm_sel", 32'(norm_sel), 32'd0);
    endtask

    task automatic t_sweep;
        for (int pg = 0; pg < 16; pg++) begin
            int bad = 0;
            wr_page(8'(pg));
            for (int a = 0; a < 65536; a += 64) begin
                for (int m = 0; m < 4; m++) begin
                    logic [15:0] aa;
                    logic ov, ed, en;
                    aa = 16'(a) | 16'(a[6] ? 16'h3F : 16'h00);
                    drive(aa, 1, 0, m[0], m[1]);
                    ov = m_ovl(aa, 4'(pg), m[0]);
                    ed = ov && m[1];
                    en = !ov;
                    if ((dbg_sel && norm_sel) || dbg_sel !== ed || norm_sel !== en
                        || glb_addr !== m_glb(aa, 4'(pg)))
                        bad++;
                end
            end
            chk("R10", $sformatf("sweep page %0d mismatches", pg), 32'(bad), 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_fixed();
        t_window();
        t_page_write();
        t_dbg_top();
        t_dbg_alias();
        t_no_cycle();
        t_dbg_off();
        t_no_strobe();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule